// File: doc/BRIEF.md
# Four-Channel Power-Down Supervisor

This block decides, for each of four voice channels, whether the channel is running or powered down, and whether the whole device sits in a global low-power state. A channel can be shut down in three ways, each with its own way back. The first is a shutdown pin held high long enough. The second is a loss of frame timing. The third is the absence of the master clock.

Each shutdown pin passes through a two-flop synchronizer. A counter then qualifies it before it takes effect. A test-enable input suppresses entry into pin-triggered shutdown. Frame timing is watched per channel by a counter of clocks since the last frame-sync rising edge in either direction. The limit is a whole number of frame periods, taken from a clocks-per-frame parameter.

In wide mode, the four channels occupy consecutive slots behind one pair of channel-0 syncs. All channels then follow those syncs and use a shorter loss window. The per-channel active flag and output-enable feed the serial slot drivers and the receive capture logic downstream.

Top module: `pdsup_top`

## Requirements
- R1: A shutdown pin takes effect only after its synchronized level has been high for PDN_QUAL (16) consecutive clocks. Once qualified, the channel's active flag drops a few clocks later. A high pulse shorter than that leaves the channel active.
- R2: While test_en is 1, a qualified shutdown pin does not shut its channel down.
- R3: A pin-shut channel restarts only after its synchronized pin has been low for PDN_QUAL clocks and a frame-sync rising edge then arrives. An edge that arrives before the low run completes does not restart it.
- R4: A rising edge on either the transmit or the receive sync of a channel keeps it alive. A channel with only one of the two syncs running stays active.
- R5: In narrow mode (wide_mode=0), a channel with no sync rising edge for FRAME_CLKS*MISS_FRAMES clocks goes down. The next sync edge brings it back.
- R6: In wide mode (wide_mode=1), every channel follows fsx[0]/fsr[0] and ignores its own syncs. No edge on those for FRAME_CLKS*WIDE_MISS_FRAMES clocks forces all channels down and sets global_down.
- R7: After reset, all channels are inactive, all output-enables are 0 and global_down is 1. This holds until frame syncs are seen.
- R8: ch_oe[i] is 1 only while ch_active[i] is 1, so a shut channel never drives its transmit slot and its receive data is ignored.
- R9: When clk_present is 0, global_down is 1 and every channel is inactive on the next clock.
- R10: global_down is 1 when all relevant syncs are lost (all four channels in narrow mode, channel 0 in wide mode) or when all four shutdown pins are qualified.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_pin | input | 4 | Per-channel shutdown request pins, asynchronous |
| test_en | input | 1 | Test enable; blocks pin-triggered shutdown |
| fsx | input | 4 | Per-channel transmit frame syncs |
| fsr | input | 4 | Per-channel receive frame syncs |
| wide_mode | input | 1 | 0: per-channel syncs; 1: all channels framed by channel 0 |
| clk_present | input | 1 | Flag from the clock-loss detector |
| ch_active | output | 4 | Per-channel running flag |
| ch_oe | output | 4 | Per-channel output enable for slot drivers |
| global_down | output | 1 | Whole-device low-power state |

## Verification
The in-line properties check the following on every cycle:
- a shutdown only begins after the synchronized pin was high, and never while test_en was set;
- a pin-shut channel or a lost-sync channel only restarts in the cycle after a sync edge;
- a missing clock or four qualified pins force global shutdown on the next clock;
- a lost channel-0 sync in wide mode drops every channel.

Only the bench's scenarios show the rest:
- the 16-clock qualification window and the ignored short pulse;
- the early edge that must not release a channel;
- the counted loss windows in each mode;
- survival with one sync direction missing;
- the starting state after reset.

// File: rtl/pdsup_pkg.sv
package pdsup_pkg;

    localparam int unsigned PDSUP_NCH = 4;

    typedef enum logic {
        FRAMING_NARROW = 1'b0,
        FRAMING_WIDE   = 1'b1
    } framing_e;

endpackage

// File: rtl/pdsup_pin_qual.sv
module pdsup_pin_qual #(
    parameter int unsigned PDN_QUAL = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pdn_pin,
    input  logic test_en,
    input  logic frame_edge,
    output logic pin_down
);

    localparam int unsigned CW = $clog2(PDN_QUAL + 1);
    localparam logic [CW-1:0] QUAL_W = CW'(PDN_QUAL);

    typedef struct packed {
        logic          meta;
        logic          sync;
        logic [CW-1:0] hi_run;
        logic [CW-1:0] lo_run;
        logic          down;
        logic          armed;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.meta = pdn_pin;
        st_d.sync = st_q.meta;

        if (st_q.sync) begin
            st_d.hi_run = (st_q.hi_run == QUAL_W) ? st_q.hi_run : st_q.hi_run + 1'b1;
            st_d.lo_run = '0;
        end else begin
            st_d.hi_run = '0;
            st_d.lo_run = (st_q.lo_run == QUAL_W) ? st_q.lo_run : st_q.lo_run + 1'b1;
        end

        if (!st_q.down) begin
            st_d.armed = 1'b0;
            if (st_q.hi_run == QUAL_W && !test_en) begin
                st_d.down = 1'b1;
            end
        end else begin
            if (st_q.sync) begin
                st_d.armed = 1'b0;
            end else if (st_q.lo_run == QUAL_W) begin
                st_d.armed = 1'b1;
            end
            if (st_q.armed && !st_q.sync && frame_edge) begin
                st_d.down  = 1'b0;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_down = st_q.down;

    assert_entry_after_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.down) |-> $past(st_q.sync, 2));

    assert_test_blocks_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.down) |-> !$past(test_en));

    assert_release_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.down) |-> ($past(frame_edge) && !$past(st_q.sync)));

endmodule

// File: rtl/pdsup_sync_watch.sv
module pdsup_sync_watch #(
    parameter int unsigned FRAME_CLKS       = 256,
    parameter int unsigned MISS_FRAMES      = 32,
    parameter int unsigned WIDE_MISS_FRAMES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsx,
    input  logic fsr,
    input  logic wide_mode,
    output logic frame_edge,
    output logic lost
);

    import pdsup_pkg::*;

    localparam int unsigned NARROW_LIM = FRAME_CLKS * MISS_FRAMES;
    localparam int unsigned WIDE_LIM   = FRAME_CLKS * WIDE_MISS_FRAMES;
    localparam int unsigned MAX_LIM    = (NARROW_LIM > WIDE_LIM) ? NARROW_LIM : WIDE_LIM;
    localparam int unsigned CW         = $clog2(MAX_LIM + 1);

    typedef struct packed {
        logic          fsx_p;
        logic          fsr_p;
        logic [CW-1:0] cnt;
        logic          lost;
    } watch_st_t;

    watch_st_t     st_d, st_q;
    logic [CW-1:0] limit;

    assign frame_edge = (fsx && !st_q.fsx_p) || (fsr && !st_q.fsr_p);
    assign limit = (framing_e'(wide_mode) == FRAMING_WIDE) ? CW'(WIDE_LIM) : CW'(NARROW_LIM);

    always_comb begin
        st_d       = st_q;
        st_d.fsx_p = fsx;
        st_d.fsr_p = fsr;
        if (frame_edge) begin
            st_d.cnt  = '0;
            st_d.lost = 1'b0;
        end else begin
            st_d.cnt  = (st_q.cnt >= limit) ? st_q.cnt : st_q.cnt + 1'b1;
            st_d.lost = (st_d.cnt >= limit);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.fsx_p <= 1'b0;
            st_q.fsr_p <= 1'b0;
            st_q.cnt   <= CW'(MAX_LIM);
            st_q.lost  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign lost = st_q.lost;

    assert_recover_on_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.lost) |-> $past(frame_edge));

    assert_no_loss_at_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.lost) |-> !$past(frame_edge));

endmodule

// File: rtl/pdsup_top.sv
module pdsup_top #(
    parameter int unsigned FRAME_CLKS       = 256,
    parameter int unsigned MISS_FRAMES      = 32,
    parameter int unsigned WIDE_MISS_FRAMES = 4,
    parameter int unsigned PDN_QUAL         = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] pdn_pin,
    input  logic       test_en,
    input  logic [3:0] fsx,
    input  logic [3:0] fsr,
    input  logic       wide_mode,
    input  logic       clk_present,
    output logic [3:0] ch_active,
    output logic [3:0] ch_oe,
    output logic       global_down
);

    import pdsup_pkg::*;

    localparam int unsigned NCH = PDSUP_NCH;

    typedef struct packed {
        logic [NCH-1:0] active;
        logic           gdown;
    } top_st_t;

    top_st_t        st_d, st_q;
    logic [NCH-1:0] src_x, src_r;
    logic [NCH-1:0] edge_w, lost_w, pin_down_w;
    logic           sync_gone;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        assign src_x[i] = wide_mode ? fsx[0] : fsx[i];
        assign src_r[i] = wide_mode ? fsr[0] : fsr[i];

        pdsup_sync_watch #(
            .FRAME_CLKS      (FRAME_CLKS),
            .MISS_FRAMES     (MISS_FRAMES),
            .WIDE_MISS_FRAMES(WIDE_MISS_FRAMES)
        ) u_watch (
            .clk       (clk),
            .rst_n     (rst_n),
            .fsx       (src_x[i]),
            .fsr       (src_r[i]),
            .wide_mode (wide_mode),
            .frame_edge(edge_w[i]),
            .lost      (lost_w[i])
        );

        pdsup_pin_qual #(
            .PDN_QUAL(PDN_QUAL)
        ) u_qual (
            .clk       (clk),
            .rst_n     (rst_n),
            .pdn_pin   (pdn_pin[i]),
            .test_en   (test_en),
            .frame_edge(edge_w[i]),
            .pin_down  (pin_down_w[i])
        );
    end

    assign sync_gone = wide_mode ? lost_w[0] : (&lost_w);

    always_comb begin
        st_d       = st_q;
        st_d.gdown = !clk_present || sync_gone || (&pin_down_w);
        for (int i = 0; i < NCH; i++) begin
            st_d.active[i] = !st_d.gdown && !pin_down_w[i] && !lost_w[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.active <= '0;
            st_q.gdown  <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ch_active   = st_q.active;
    assign ch_oe       = st_q.active;
    assign global_down = st_q.gdown;

    assert_clock_loss_global_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_present |=> (global_down && ch_active == '0));

    assert_all_pins_global_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (&pin_down_w) |=> global_down);

    assert_wide_loss_all_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wide_mode && lost_w[0]) |=> (ch_active == '0 && global_down));

    assert_pin_down_inactive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_down_w != '0) |=> ((ch_oe & $past(pin_down_w)) == '0));

endmodule

// File: tb/pdsup_top_bench.sv
module pdsup_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam int FC = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] pdn_pin;
    logic       test_en;
    logic [3:0] fsx, fsr;
    logic       wide_mode;
    logic       clk_present;
    logic [3:0] ch_active, ch_oe;
    logic       global_down;

    logic [3:0] en_x, en_r;
    int         req2 = 0, ack2 = 0;
    int         ph = 0;
    int         total = 0, bad = 0;
    bit         done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdsup_top #(
        .FRAME_CLKS(FC), .MISS_FRAMES(4), .WIDE_MISS_FRAMES(2), .PDN_QUAL(16)
    ) u_pdsup_top (
        .clk(clk), .rst_n(rst_n), .pdn_pin(pdn_pin), .test_en(test_en),
        .fsx(fsx), .fsr(fsr), .wide_mode(wide_mode), .clk_present(clk_present),
        .ch_active(ch_active), .ch_oe(ch_oe), .global_down(global_down)
    );

    always @(negedge clk) begin
        ph = (ph + 1) % FC;
        for (int i = 0; i < 4; i++) begin
            fsx[i] = en_x[i] && (ph == i);
            fsr[i] = en_r[i] && (ph == i + 4);
        end
        if (req2 != ack2) begin
            fsx[2] = 1'b1;
            ack2 = req2;
        end
    end

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic see(input string tag, input logic [3:0] act_exp, input logic gd_exp);
        chk(tag, {global_down, ch_active}, {gd_exp, act_exp});
        chk({tag, " oe R8"}, {1'b0, ch_oe}, {1'b0, act_exp});
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; pdn_pin = '0; test_en = 1'b0; wide_mode = 1'b0;
        clk_present = 1'b1; en_x = '0; en_r = '0; fsx = '0; fsr = '0;
        wait_n(5);
        see("R7 in reset", 4'b0000, 1'b1);
        rst_n = 1'b1;
        wait_n(5);
        see("R7 no syncs yet", 4'b0000, 1'b1);

        en_x = 4'hF; en_r = 4'hF;
        wait_n(40);
        see("R4 syncs bring channels up", 4'hF, 1'b0);

        // R1: short pulse has no effect
        pdn_pin[2] = 1'b1; wait_n(10); pdn_pin[2] = 1'b0;
        wait_n(30);
        see("R1 short pulse ignored", 4'hF, 1'b0);

        pdn_pin[2] = 1'b1;
        wait_n(15);
        see("R1 not before 16 clocks", 4'hF, 1'b0);
        wait_n(15);
        see("R1 qualified shutdown", 4'b1011, 1'b0);

        test_en = 1'b1; pdn_pin[1] = 1'b1;
        wait_n(40);
        see("R2 test_en blocks shutdown", 4'b1011, 1'b0);
        pdn_pin[1] = 1'b0; test_en = 1'b0;
        wait_n(20);

        // R3 release sequence on channel 2
        en_x[2] = 1'b0; en_r[2] = 1'b0;
        pdn_pin[2] = 1'b0;
        wait_n(5);
        req2++;
        wait_n(25);
        see("R3 early edge does not release", 4'b1011, 1'b0);
        req2++;
        wait_n(5);
        see("R3 release after low run and edge", 4'hF, 1'b0);
        en_x[2] = 1'b1; en_r[2] = 1'b1;
        wait_n(20);

        en_x[1] = 1'b0;
        wait_n(150);
        see("R4 one direction missing stays up", 4'hF, 1'b0);
        en_r[1] = 1'b0;
        wait_n(40);
        see("R5 inside loss window", 4'hF, 1'b0);
        wait_n(60);
        see("R5 loss after window", 4'b1101, 1'b0);
        en_x[1] = 1'b1; en_r[1] = 1'b1;
        wait_n(30);
        see("R5 recovery on edge", 4'hF, 1'b0);

        wide_mode = 1'b1; en_x[3:1] = '0; en_r[3:1] = '0;
        wait_n(150);
        see("R6 channels follow channel 0", 4'hF, 1'b0);
        en_x[0] = 1'b0; en_r[0] = 1'b0;
        wait_n(10);
        see("R6 inside wide window", 4'hF, 1'b0);
        wait_n(50);
        see("R6 wide loss forces all down", 4'h0, 1'b1);
        en_x[0] = 1'b1; en_r[0] = 1'b1;
        wait_n(30);
        see("R6 wide recovery", 4'hF, 1'b0);
        wide_mode = 1'b0; en_x = 4'hF; en_r = 4'hF;
        wait_n(40);
        see("R5 narrow restored", 4'hF, 1'b0);

        clk_present = 1'b0;
        wait_n(3);
        see("R9 clock missing", 4'h0, 1'b1);
        clk_present = 1'b1;
        wait_n(5);
        see("R9 clock back", 4'hF, 1'b0);

        pdn_pin = 4'hF;
        wait_n(40);
        see("R10 all pins high", 4'h0, 1'b1);
        pdn_pin = 4'h0;
        wait_n(60);
        see("R10 pins released", 4'hF, 1'b0);

        en_x = '0; en_r = '0;
        wait_n(100);
        see("R10 all syncs lost", 4'h0, 1'b1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog (all R) actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule